// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Error Flags

This block receives asynchronous serial frames on a single line. It samples the line on a clock enable that pulses sixteen times per bit period. Each frame is a start bit, eight data bits sent least significant bit first, an optional parity bit and one or two stop bits. Every completed frame writes its byte into a receive data register. A clean frame raises a data-full flag. A frame with a bad stop bit or a bad parity bit raises a framing-error or parity-error flag instead and leaves data-full as it was.

Software reaches the block through a small register port with two addresses. Reading the data register drops data-full. Each error flag is sticky. While either one is set, the receiver ignores new frames. A flag clears only after software has read it as 1 and then writes a 0 into its bit position. The received byte leaves only through this register read, so the block has no streaming output and applies no back-pressure: a byte that is not read in time is overwritten by the next clean frame.

Top module: `serial_rx_flags`

## Requirements
- R1: After a valid start bit, eight data bits are each sampled once at mid-bit and assembled least significant bit first. At the end of a clean frame the byte appears at data address 1, and status bit 0 (data-full) reads 1.
- R2: A read of data address 1 clears status bit 0. Status bits 7..3 always read 0.
- R3: A falling edge starts a frame only if the line is still low at the eighth oversampling tick. A shorter low pulse is dropped, and the receiver is ready for the next frame.
- R4: If the first stop bit samples as 0, status bit 2 (framing error) becomes 1. The byte is still written to the data register, and status bit 0 keeps its prior value.
- R5: With two stop bits selected (`two_stop`=1), a 0 on the second stop bit raises no error.
- R6: With `parity_en`=1, the bit after the data is parity. In even mode (`parity_odd`=0) the data ones plus the parity bit must be even; in odd mode they must be odd. A mismatch sets status bit 1 (parity error), stores the byte and leaves status bit 0 unchanged.
- R7: While status bit 1 or bit 2 is 1, frames on the line are not received. The data register and status bit 0 stay unchanged.
- R8: An error flag clears only on a write of 0 to its bit at status address 0 after a status read that returned that bit as 1. A write of 0 without that prior read, or a write of 1, leaves the flag set.
- R9: While `rx_enable` is 0, no frame is received, and both error flags keep their state.
- R10: After reset, the status register and the data register read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Oversampling enable, 16 pulses per bit |
| rx_line | input | 1 | Serial input line, idle high |
| rx_enable | input | 1 | Receiver enable |
| parity_en | input | 1 | Expect a parity bit after the data |
| parity_odd | input | 1 | 1 = odd parity, 0 = even parity |
| two_stop | input | 1 | Frame carries two stop bits |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = status, 1 = received data |
| reg_wdata | input | 8 | Write data (status address only) |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |

## Verification
The hardest situation to reach from the ports is the clear handshake that meets the stalled receiver. An error flag must first be set by a corrupted frame. Then a second frame has to arrive while the flag is up, so the bench can observe that it is dropped. After that, a blind write of 0 must fail, and the read-then-write sequence must succeed. The bench builds corrupted frames by driving a 0 stop bit or an inverted parity bit. It sends a follow-up frame carrying a different byte, so that any unwanted capture shows up in the data register. The clear writes are issued in both orders.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef enum logic [2:0] {
    RX_IDLE  = 3'd0,
    RX_START = 3'd1,
    RX_DATA  = 3'd2,
    RX_PAR   = 3'd3,
    RX_STOP1 = 3'd4,
    RX_STOP2 = 3'd5
  } rx_state_t;

  localparam int unsigned ST_FULL = 0;
  localparam int unsigned ST_PERR = 1;
  localparam int unsigned ST_FERR = 2;

  localparam logic ADDR_STATUS = 1'b0;
  localparam logic ADDR_DATA   = 1'b1;
endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b1;
          else        chain[i] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b1;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/serial_rx_framer.sv
module serial_rx_framer
  import serial_rx_pkg::*;
#(
  parameter int unsigned DATA_BITS  = 8,
  parameter int unsigned OVERSAMPLE = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 line,
  input  logic                 enable,
  input  logic                 blocked,
  input  logic                 par_en,
  input  logic                 par_odd,
  input  logic                 stop2,
  output logic                 done,
  output logic [DATA_BITS-1:0] data,
  output logic                 frame_err,
  output logic                 par_err
);
  localparam int unsigned CW   = $clog2(OVERSAMPLE);
  localparam int unsigned BW   = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam logic [CW-1:0] MID  = CW'(OVERSAMPLE / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVERSAMPLE - 1);
  localparam logic [BW-1:0] TOPB = BW'(DATA_BITS - 1);

  rx_state_t              state;
  logic [CW-1:0]          cnt;
  logic [BW-1:0]          bitn;
  logic [DATA_BITS-1:0]   shreg;
  logic                   par_acc;
  logic                   at_end;

  assign at_end = (cnt == LAST);
  assign data   = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= RX_IDLE;
      cnt       <= '0;
      bitn      <= '0;
      shreg     <= '0;
      par_acc   <= 1'b0;
      done      <= 1'b0;
      frame_err <= 1'b0;
      par_err   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!enable) begin
        state <= RX_IDLE;
        cnt   <= '0;
      end else if (tick) begin
        unique case (state)
          RX_IDLE: begin
            cnt <= '0;
            if (!line && !blocked) state <= RX_START;
          end
          RX_START: begin
            if (cnt == MID) begin
              cnt     <= '0;
              bitn    <= '0;
              par_acc <= 1'b0;
              state   <= line ? RX_IDLE : RX_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_DATA: begin
            if (at_end) begin
              cnt     <= '0;
              shreg   <= {line, shreg[DATA_BITS-1:1]};
              par_acc <= par_acc ^ line;
              if (bitn == TOPB) state <= par_en ? RX_PAR : RX_STOP1;
              else              bitn  <= bitn + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_PAR: begin
            if (at_end) begin
              cnt     <= '0;
              par_acc <= par_acc ^ line;
              state   <= RX_STOP1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_STOP1: begin
            if (at_end) begin
              cnt       <= '0;
              done      <= 1'b1;
              frame_err <= !line;
              par_err   <= par_en && (par_acc != par_odd);
              state     <= stop2 ? RX_STOP2 : RX_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_STOP2: begin
            if (at_end) begin
              cnt   <= '0;
              state <= RX_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

  // R7: a raised error flag keeps the receiver parked in idle
  a_r7_no_start_when_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_IDLE && blocked) |=> (state == RX_IDLE));

  // R9: no frame completes while the receiver is disabled
  a_r9_no_done_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable) |=> !done);

  // R6: a parity fault is only reported with parity enabled
  a_r6_perr_needs_parity: assert property (@(posedge clk) disable iff (!rst_n)
    (done && par_err) |-> $past(par_en));
endmodule

// File: rtl/serial_rx_status.sv
module serial_rx_status
  import serial_rx_pkg::*;
#(
  parameter int unsigned DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic                 done,
  input  logic [DATA_BITS-1:0] rx_byte,
  input  logic                 fe_in,
  input  logic                 pe_in,
  input  logic                 rd,
  input  logic                 wr,
  input  logic                 addr,
  input  logic [7:0]           wdata,
  output logic [7:0]           rdata,
  output logic                 blocked
);
  logic [DATA_BITS-1:0] rdr;
  logic full, ferr, perr, fe_arm, pe_arm;
  logic rd_stat, rd_data, wr_stat;

  assign rd_stat = rd && (addr == ADDR_STATUS);
  assign rd_data = rd && (addr == ADDR_DATA);
  assign wr_stat = wr && (addr == ADDR_STATUS);
  assign blocked = ferr || perr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdr    <= '0;
      full   <= 1'b0;
      ferr   <= 1'b0;
      perr   <= 1'b0;
      fe_arm <= 1'b0;
      pe_arm <= 1'b0;
    end else begin
      if (rd_data) full <= 1'b0;
      if (rd_stat) begin
        if (ferr) fe_arm <= 1'b1;
        if (perr) pe_arm <= 1'b1;
      end
      if (wr_stat) begin
        if (!wdata[ST_FERR] && fe_arm) begin
          ferr   <= 1'b0;
          fe_arm <= 1'b0;
        end
        if (!wdata[ST_PERR] && pe_arm) begin
          perr   <= 1'b0;
          pe_arm <= 1'b0;
        end
      end
      if (done && enable) begin
        rdr <= rx_byte;
        if (fe_in) ferr <= 1'b1;
        if (pe_in) perr <= 1'b1;
        if (!fe_in && !pe_in) full <= 1'b1;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_DATA) begin
      rdata[DATA_BITS-1:0] = rdr;
    end else begin
      rdata[ST_FULL] = full;
      rdata[ST_PERR] = perr;
      rdata[ST_FERR] = ferr;
    end
  end

  // R4 / R6: an erroneous frame never raises data-full
  a_r4_err_keeps_full: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (fe_in || pe_in) && !rd_data) |=> (full == $past(full)));

  // R8: a framing flag falls only after it was read as 1
  a_r8_fe_clear_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ferr) |-> $past(fe_arm && wr_stat));

  // R8: same rule for the parity flag
  a_r8_pe_clear_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(perr) |-> $past(pe_arm && wr_stat));

  // R9: flags hold while disabled and untouched by software
  a_r9_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !wr) |=> (ferr == $past(ferr) && perr == $past(perr)));
endmodule

// File: rtl/serial_rx_flags.sv
module serial_rx_flags #(
  parameter int unsigned DATA_BITS   = 8,
  parameter int unsigned OVERSAMPLE  = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       os_tick,
  input  logic       rx_line,
  input  logic       rx_enable,
  input  logic       parity_en,
  input  logic       parity_odd,
  input  logic       two_stop,
  input  logic       reg_rd,
  input  logic       reg_wr,
  input  logic       reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata
);
  logic                 line_s;
  logic                 done;
  logic [DATA_BITS-1:0] rx_byte;
  logic                 fe, pe, blocked;

  serial_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst_n (rst_n), .din (rx_line), .dout (line_s)
  );

  serial_rx_framer #(.DATA_BITS(DATA_BITS), .OVERSAMPLE(OVERSAMPLE)) u_framer (
    .clk (clk), .rst_n (rst_n), .tick (os_tick), .line (line_s),
    .enable (rx_enable), .blocked (blocked), .par_en (parity_en),
    .par_odd (parity_odd), .stop2 (two_stop), .done (done),
    .data (rx_byte), .frame_err (fe), .par_err (pe)
  );

  serial_rx_status #(.DATA_BITS(DATA_BITS)) u_status (
    .clk (clk), .rst_n (rst_n), .enable (rx_enable), .done (done),
    .rx_byte (rx_byte), .fe_in (fe), .pe_in (pe), .rd (reg_rd),
    .wr (reg_wr), .addr (reg_addr), .wdata (reg_wdata),
    .rdata (reg_rdata), .blocked (blocked)
  );
endmodule

// File: tb/serial_rx_flags_test.sv
module serial_rx_flags_test;
  localparam int PERIOD = 10;
  localparam int OS = 16;

  logic clk = 0, rst_n = 0;
  logic os_tick = 1, rx_line = 1, rx_enable = 1;
  logic parity_en = 0, parity_odd = 0, two_stop = 0;
  logic reg_rd = 0, reg_wr = 0, reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  int total = 0, bad = 0;

  always #(PERIOD/2) clk = ~clk;

  serial_rx_flags uut (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_line(rx_line),
    .rx_enable(rx_enable), .parity_en(parity_en), .parity_odd(parity_odd),
    .two_stop(two_stop), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic rd_reg(input logic a, output logic [7:0] v);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    #1 v = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic wr_reg(input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = 0; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic hold_bit(input logic v);
    for (int k = 0; k < OS; k++) begin @(negedge clk); rx_line = v; end
  endtask

  // sends one frame under the current config; par_flip inverts the parity bit
  task automatic send(input logic [7:0] b, input logic s1, input logic s2, input logic par_flip);
    hold_bit(1'b0);
    for (int i = 0; i < 8; i++) hold_bit(b[i]);
    if (parity_en) hold_bit((^b) ^ parity_odd ^ par_flip);
    hold_bit(s1);
    if (two_stop) hold_bit(s2);
    for (int k = 0; k < 8; k++) begin @(negedge clk); rx_line = 1; end
  endtask

  initial begin
    #(PERIOD*200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd_reg(0, v); chk("R10 status after reset", v, 8'h00);
    rd_reg(1, v); chk("R10 data after reset", v, 8'h00);

    // R1 R2 R6 sweep: every byte, rotating through four frame formats
    for (int b = 0; b < 256; b++) begin
      parity_en  = (b % 4 == 1) || (b % 4 == 2);
      parity_odd = (b % 4 == 2);
      two_stop   = (b % 4 == 3);
      send(8'(b), 1'b1, 1'b1, 1'b0);
      rd_reg(0, v); chk("R1 full set", v, 8'h01);
      rd_reg(1, v); chk("R1 byte", v, 8'(b));
      rd_reg(0, v); chk("R2 full cleared", v, 8'h00);
    end
    parity_en = 0; parity_odd = 0; two_stop = 0;

    // R3 short low glitch ignored, then a real frame still captured
    for (int k = 0; k < 5; k++) begin @(negedge clk); rx_line = 0; end
    for (int k = 0; k < 40; k++) begin @(negedge clk); rx_line = 1; end
    rd_reg(0, v); chk("R3 glitch no frame", v, 8'h00);
    send(8'h3C, 1'b1, 1'b1, 1'b0);
    rd_reg(1, v); chk("R3 frame after glitch", v, 8'h3C);

    // R5 second stop bit 0 ignored
    two_stop = 1;
    send(8'hA7, 1'b1, 1'b0, 1'b0);
    rd_reg(0, v); chk("R5 no error on stop2", v, 8'h01);
    rd_reg(1, v); chk("R5 byte", v, 8'hA7);
    two_stop = 0;

    // R4 framing error: byte stored, full stays clear
    send(8'h5A, 1'b0, 1'b1, 1'b0);
    rd_reg(1, v); chk("R4 byte stored", v, 8'h5A);
    rd_reg(0, v); chk("R4 ferr, no full", v, 8'h04);
    // R7 stalled while flag set
    send(8'hC3, 1'b1, 1'b1, 1'b0);
    rd_reg(1, v); chk("R7 frame dropped", v, 8'h5A);
    rd_reg(0, v); chk("R7 status unchanged", v, 8'h04);
    // R8 write of 1 after read does not clear
    wr_reg(8'h04);
    rd_reg(0, v); chk("R8 write one no clear", v, 8'h04);
    wr_reg(8'h00);
    rd_reg(0, v); chk("R8 read then zero clears", v, 8'h00);

    // R6 parity error, odd mode; R8 blind write does not clear
    rst_n = 0; @(negedge clk); rst_n = 1;
    parity_en = 1; parity_odd = 1;
    send(8'h81, 1'b1, 1'b1, 1'b1);
    wr_reg(8'h00);
    rd_reg(1, v); chk("R6 byte stored", v, 8'h81);
    rd_reg(0, v); chk("R8 blind write no clear", v, 8'h02);
    // R9 disable keeps the flag and ignores frames
    rx_enable = 0;
    send(8'h11, 1'b1, 1'b1, 1'b0);
    rd_reg(0, v); chk("R9 flag held disabled", v, 8'h02);
    rd_reg(1, v); chk("R9 no capture disabled", v, 8'h81);
    rx_enable = 1;
    wr_reg(8'h00);
    rd_reg(0, v); chk("R8 perr cleared", v, 8'h00);
    // R6 even mode, wrong parity
    parity_odd = 0;
    send(8'h07, 1'b1, 1'b1, 1'b1);
    rd_reg(0, v); chk("R6 even mismatch", v, 8'h02);
    rd_reg(0, v); wr_reg(8'h00);
    // R9 disabled with line activity, clean receiver
    rx_enable = 0;
    send(8'h22, 1'b1, 1'b1, 1'b0);
    rd_reg(0, v); chk("R9 no frame disabled", v, 8'h00);
    rx_enable = 1;
    send(8'h96, 1'b1, 1'b1, 1'b0);
    rd_reg(1, v); chk("R6 even match", v, 8'h96);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule